// File: doc/BRIEF.md
# Register access master for a security-module SPI target

This block lets on-chip logic read or write one register of a security-module style SPI target. A host presents a request over a ready/valid handshake. The request carries a direction, a register offset, a byte count and up to four bytes of write data. The block opens a single chip-select frame and sends a four-byte header. The header is a command byte followed by a 24-bit bus address, most significant byte first. The bus address is the offset plus a fixed base.

For reads, the target may not be ready when the header ends. It signals this through bit 0 of the byte it returns while the last header byte goes out. The master then clocks dummy zero bytes until the target reports ready or a poll limit runs out. It then moves the data bytes, least significant byte first, and releases chip select. Writes skip the readiness check entirely. A request whose byte count is out of range is refused at once without touching the SPI pins.

The SPI side is mode 0. The serial clock idles low and comes from a parameterized divider of the system clock. Outgoing data changes on the falling edge, and incoming data is sampled on the rising edge.

Top module: `secmod_spi_access`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is taken on a clock where `req_valid` and `req_ready` are both high, and `req_ready` is low on the next clock for any accepted request of legal length.
- R2: The first byte of every frame is the command byte. Bit 7 is 1 for a read and 0 for a write, bit 6 is 0, and bits 5:0 hold the byte count minus one.
- R3: Bytes 2 to 4 of the frame are the 24-bit address (`ADDR_BASE` + `req_off`) modulo 2^24, most significant byte first.
- R4: A byte count of 0 or above `MAX_BYTES` causes the following response. On the next clock, `rsp_done` pulses with `rsp_err` = 1 and `rsp_timeout` = 0. No chip-select frame is opened.
- R5: On a read, the target may return a byte with bit 0 set during the fourth header byte. In that case the data bytes follow the header directly, with no poll bytes.
- R6: On a read, the target may return bit 0 clear during the fourth header byte. In that case the master sends 0x00 poll bytes, one at a time, until a received byte has bit 0 set. The data phase begins right after that byte.
- R7: Polling stops after at most `MAX_POLL` bytes. `rsp_timeout` is 1 at `rsp_done` only if the last allowed poll byte still had bit 0 clear. A ready bit seen on that last poll gives `rsp_timeout` = 0. After a timeout, the data phase still runs.
- R8: Chip select goes low once per legal request. It stays low through the header, polling and data, and is high again by the clock in which `rsp_done` pulses. `spi_sclk` is low whenever chip select is high.
- R9: During the read data phase the master sends 0x00. The i-th received data byte lands in `rsp_rdata[8i+7:8i]`, and bytes beyond the count read as 0.
- R10: A write sends the header and then `req_len` bytes of `req_wdata`, least significant byte first. No poll bytes are sent, whatever the target returns on the fourth header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_off | input | OFF_W | Register offset added to the base address |
| req_len | input | LEN_W | Byte count, legal range 1 to MAX_BYTES |
| req_wdata | input | 8*MAX_BYTES | Write data, byte 0 sent first |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8*MAX_BYTES | Read data, valid from rsp_done to next accept |
| rsp_err | output | 1 | Request refused for its byte count |
| rsp_timeout | output | 1 | Poll limit reached without a ready bit |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |

## Verification
Two decisions can land on the same received byte: the poll limit being reached, and the target raising its ready bit. The bench holds the target back for exactly `MAX_POLL` poll bytes, then for one more. With `MAX_POLL` polls the final poll carries the ready bit, and the read must end with `rsp_timeout` at 0. With one more, the read must end with the flag at 1 and still deliver the data bytes. The same coincidence arises when the ready decision falls on the last header byte. The bench covers this by sweeping zero, one and a few wait bytes for every byte count, and by giving write frames a "not ready" fourth byte that must be ignored.

// File: rtl/secmod_spi_pkg.sv
package secmod_spi_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_POLL = 2'd2,
    S_DATA = 2'd3
  } seq_state_e;

  // Byte count legal range check
  function automatic logic len_in_range(input int len, input int max_bytes);
    return (len >= 1) && (len <= max_bytes);
  endfunction

  // Wire address: base plus offset, wrapped to 24 bits
  function automatic logic [23:0] form_addr(input logic [23:0] base, input logic [23:0] off);
    return base + off;
  endfunction

  // Header byte by position: 0 = command, 1..3 = address high to low
  function automatic logic [7:0] hdr_byte(input logic rd, input logic [5:0] lenm1,
                                          input logic [23:0] addr, input logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0:    b = {rd, 1'b0, lenm1};
      2'd1:    b = addr[23:16];
      2'd2:    b = addr[15:8];
      default: b = addr[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/secmod_spi_shift.sv
module secmod_spi_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int HDW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic           busy;
  logic [HDW-1:0] div_cnt;
  logic [2:0]     nbit;
  logic [7:0]     tx_sh;
  logic [7:0]     rx_sh;
  logic           half_tick;

  assign half_tick = (div_cnt == HDW'(HALF_DIV - 1));
  assign rx        = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      nbit    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          tx_sh   <= tx;
          mosi    <= tx[7];
          div_cnt <= '0;
          nbit    <= '0;
          sclk    <= 1'b0;
        end
      end else if (half_tick) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (nbit == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            nbit  <= nbit + 3'd1;
            tx_sh <= {tx_sh[6:0], 1'b0};
            mosi  <= tx_sh[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + HDW'(1);
      end
    end
  end

endmodule

// File: rtl/secmod_spi_seq.sv
module secmod_spi_seq
  import secmod_spi_pkg::*;
#(
  parameter int          OFF_W     = 16,
  parameter logic [23:0] ADDR_BASE = 24'hD40000,
  parameter int          MAX_POLL  = 50,
  parameter int          MAX_BYTES = 4,
  parameter int          LEN_W     = 3,
  parameter int          PCNT_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_rd,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  output logic                   eng_start,
  output logic [7:0]             eng_tx,
  input  logic                   eng_done,
  input  logic [7:0]             eng_rx,
  output logic                   cs_n,
  output logic                   rsp_done,
  output logic [8*MAX_BYTES-1:0] rsp_rdata,
  output logic                   rsp_err,
  output logic                   rsp_timeout,
  output logic [PCNT_W-1:0]      poll_cnt,
  output logic                   in_poll
);
  localparam int DW    = 8 * MAX_BYTES;
  localparam int IDX_W = ($clog2(MAX_BYTES) > 2) ? $clog2(MAX_BYTES) : 2;

  seq_state_e        st;
  logic              rd_q;
  logic [LEN_W-1:0]  len_q;
  logic [23:0]       addr_q;
  logic [DW-1:0]     wdata_q;
  logic [IDX_W-1:0]  idx;
  logic [PCNT_W-1:0] pcnt;
  logic              to_q;
  logic [5:0]        lenm1_q;

  // Named events
  logic accept, len_ok, hdr_last, want_wait, poll_ready, poll_give_up, data_last;
  logic [23:0] req_addr;

  assign req_ready    = (st == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign len_ok       = len_in_range(int'(req_len), MAX_BYTES);
  assign req_addr     = form_addr(ADDR_BASE, 24'(req_off));
  assign lenm1_q      = 6'(len_q - LEN_W'(1));
  assign hdr_last     = (st == S_HDR) && eng_done && (idx == IDX_W'(3));
  assign want_wait    = hdr_last && rd_q && !eng_rx[0];
  assign poll_ready   = (st == S_POLL) && eng_done && eng_rx[0];
  assign poll_give_up = (st == S_POLL) && eng_done && !eng_rx[0] && (pcnt == PCNT_W'(MAX_POLL));
  assign data_last    = (st == S_DATA) && eng_done && (int'(idx) == int'(len_q) - 1);
  assign poll_cnt     = pcnt;
  assign in_poll      = (st == S_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rd_q        <= 1'b0;
      len_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      idx         <= '0;
      pcnt        <= '0;
      to_q        <= 1'b0;
      cs_n        <= 1'b1;
      eng_start   <= 1'b0;
      eng_tx      <= '0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      rsp_done  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            rsp_rdata   <= '0;
            rsp_timeout <= 1'b0;
            if (!len_ok) begin
              rsp_done <= 1'b1;
              rsp_err  <= 1'b1;
            end else begin
              rsp_err   <= 1'b0;
              rd_q      <= req_rd;
              len_q     <= req_len;
              addr_q    <= req_addr;
              wdata_q   <= req_wdata;
              idx       <= '0;
              pcnt      <= '0;
              to_q      <= 1'b0;
              cs_n      <= 1'b0;
              eng_start <= 1'b1;
              eng_tx    <= hdr_byte(req_rd, 6'(req_len - LEN_W'(1)), req_addr, 2'd0);
              st        <= S_HDR;
            end
          end
        end
        S_HDR: begin
          if (eng_done) begin
            eng_start <= 1'b1;
            if (want_wait) begin
              pcnt   <= PCNT_W'(1);
              eng_tx <= 8'h00;
              st     <= S_POLL;
            end else if (hdr_last) begin
              idx    <= '0;
              eng_tx <= rd_q ? 8'h00 : wdata_q[7:0];
              st     <= S_DATA;
            end else begin
              idx    <= idx + IDX_W'(1);
              eng_tx <= hdr_byte(rd_q, lenm1_q, addr_q, 2'(idx + IDX_W'(1)));
            end
          end
        end
        S_POLL: begin
          if (eng_done) begin
            eng_start <= 1'b1;
            if (poll_ready || poll_give_up) begin
              to_q   <= poll_give_up;
              idx    <= '0;
              eng_tx <= 8'h00;
              st     <= S_DATA;
            end else begin
              pcnt   <= pcnt + PCNT_W'(1);
              eng_tx <= 8'h00;
            end
          end
        end
        default: begin
          if (eng_done) begin
            if (rd_q) rsp_rdata[8*int'(idx) +: 8] <= eng_rx;
            if (data_last) begin
              cs_n        <= 1'b1;
              rsp_done    <= 1'b1;
              rsp_timeout <= to_q;
              st          <= S_IDLE;
            end else begin
              idx       <= idx + IDX_W'(1);
              eng_start <= 1'b1;
              eng_tx    <= rd_q ? 8'h00 : wdata_q[8*(int'(idx) + 1) +: 8];
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/secmod_spi_access.sv
module secmod_spi_access #(
  parameter int          OFF_W     = 16,
  parameter logic [23:0] ADDR_BASE = 24'hD40000,
  parameter int          HALF_DIV  = 2,
  parameter int          MAX_POLL  = 50,
  parameter int          MAX_BYTES = 4,
  parameter int          LEN_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_rd,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  output logic                   rsp_done,
  output logic [8*MAX_BYTES-1:0] rsp_rdata,
  output logic                   rsp_err,
  output logic                   rsp_timeout,
  output logic                   spi_sclk,
  output logic                   spi_cs_n,
  output logic                   spi_mosi,
  input  logic                   spi_miso
);
  localparam int PCNT_W = $clog2(MAX_POLL + 1);

  logic              eng_start;
  logic [7:0]        eng_tx;
  logic              eng_done;
  logic [7:0]        eng_rx;
  logic [PCNT_W-1:0] poll_cnt;
  logic              in_poll;

  secmod_spi_seq #(
    .OFF_W(OFF_W), .ADDR_BASE(ADDR_BASE), .MAX_POLL(MAX_POLL),
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .PCNT_W(PCNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_off(req_off), .req_len(req_len), .req_wdata(req_wdata),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx),
    .cs_n(spi_cs_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .poll_cnt(poll_cnt), .in_poll(in_poll)
  );

  secmod_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .tx(eng_tx), .done(eng_done), .rx(eng_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

endmodule

// File: rtl/secmod_spi_chk.sv
module secmod_spi_chk #(
  parameter int MAX_POLL  = 50,
  parameter int MAX_BYTES = 4,
  parameter int LEN_W     = 3,
  parameter int PCNT_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              rsp_timeout,
  input logic [PCNT_W-1:0] poll_cnt,
  input logic              in_poll
);
  logic bad_len;
  assign bad_len = (req_len == '0) || (int'(req_len) > MAX_BYTES);

  p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad_len) |=> !req_ready);

  p_badlen_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_len) |=> (rsp_done && rsp_err && !rsp_timeout && spi_cs_n));

  p_poll_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_poll |-> !spi_cs_n);

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PCNT_W'(MAX_POLL));

  p_timeout_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_timeout) |-> rsp_done);

  p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);

  p_sclk_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> spi_cs_n);

endmodule

bind secmod_spi_access secmod_spi_chk #(
  .MAX_POLL(MAX_POLL), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .PCNT_W(PCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
  .poll_cnt(poll_cnt), .in_poll(in_poll)
);

// File: tb/sim_secmod_spi_access.sv
module sim_secmod_spi_access;
  localparam int MAXP = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rd = 1'b0;
  logic [15:0] req_off = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        rsp_timeout;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  secmod_spi_access u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_off(req_off), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_timeout(rsp_timeout), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Target model: scripted MISO stream, captured MOSI stream
  logic [7:0] ms [0:63];
  logic [7:0] mo [0:63];
  int mo_bits = 0;
  int mi_bit  = 0;
  int frames  = 0;

  function automatic logic ms_bit(input int b);
    int k = (b >> 3) > 63 ? 63 : (b >> 3);
    return ms[k][7 - (b & 7)];
  endfunction

  always @(negedge spi_cs_n) begin
    frames++;
    mo_bits  = 0;
    mi_bit   = 0;
    spi_miso = ms_bit(0);
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n && mo_bits < 512) begin
      mo[mo_bits >> 3] = {mo[mo_bits >> 3][6:0], spi_mosi};
      mo_bits++;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      mi_bit++;
      spi_miso = ms_bit(mi_bit);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b1;
    while (!rsp_done) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin ok = 1'b0; break; end
    end
  endtask

  // Rejected request: no frame, immediate error
  task automatic run_bad(input bit rd, input int len);
    int f0 = frames;
    bit ok;
    @(negedge clk);
    req_rd = rd; req_len = 3'(len); req_off = 16'h0042; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done === 1'b1, "R4", "done next clock", 32'(rsp_done), 1);
    wait_done(ok);
    chk(rsp_err === 1'b1 && rsp_timeout === 1'b0, "R4", "err/timeout",
        {30'd0, rsp_err, rsp_timeout}, 32'd2);
    repeat (3) @(negedge clk);
    chk(frames == f0 && spi_cs_n === 1'b1, "R4", "no frame", 32'(frames - f0), 0);
  endtask

  // Legal request; wt = wait bytes the target inserts (reads)
  task automatic run_ok(input bit rd, input int len, input logic [15:0] off,
                        input logic [31:0] wd, input logic [31:0] tdat, input int wt);
    int npoll, nbytes, f0;
    bit ok, tmo_exp, frame_ok;
    logic [23:0] addr;
    logic [7:0]  cmd, expb;
    logic [31:0] rexp;
    npoll   = (!rd || wt == 0) ? 0 : (wt > MAXP ? MAXP : wt);
    tmo_exp = rd && (wt > MAXP);
    nbytes  = 4 + npoll + len;
    addr    = 24'hD40000 + {8'd0, off};
    cmd     = {rd, 1'b0, 6'(len - 1)};
    for (int i = 0; i < 64; i++) ms[i] = 8'hFE;
    ms[0] = 8'hA5; ms[1] = 8'hA5; ms[2] = 8'hA5;
    ms[3] = (rd && wt == 0) ? 8'h01 : 8'hFE;
    if (rd && wt > 0 && wt <= MAXP) ms[3 + wt] = 8'h01;
    for (int i = 0; i < len; i++) ms[4 + npoll + i] = tdat[8*i +: 8];
    rexp = 32'd0;
    if (rd) for (int i = 0; i < len; i++) rexp[8*i +: 8] = tdat[8*i +: 8];
    f0 = frames;
    @(negedge clk);
    req_rd = rd; req_len = 3'(len); req_off = off; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R1", "busy after accept", 32'(req_ready), 0);
    wait_done(ok);
    chk(ok, "R8", "done reached", 32'(ok), 1);
    chk(spi_cs_n === 1'b1 && frames == f0 + 1, "R8", "one frame, cs high at done",
        32'(frames - f0), 1);
    chk(mo_bits == 8 * nbytes, rd ? (wt == 0 ? "R5" : "R6") : "R10", "frame bits",
        32'(mo_bits), 32'(8 * nbytes));
    chk(mo[0] === cmd, "R2", "command byte", {24'd0, mo[0]}, {24'd0, cmd});
    chk({mo[1], mo[2], mo[3]} === addr, "R3", "address", {8'd0, mo[1], mo[2], mo[3]},
        {8'd0, addr});
    frame_ok = 1'b1;
    for (int i = 0; i < npoll; i++) if (mo[4 + i] !== 8'h00) frame_ok = 1'b0;
    chk(frame_ok, "R6", "poll bytes zero", 32'(npoll), 32'(npoll));
    frame_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      expb = rd ? 8'h00 : wd[8*i +: 8];
      if (mo[4 + npoll + i] !== expb) frame_ok = 1'b0;
    end
    chk(frame_ok, rd ? "R9" : "R10", "data bytes on mosi", 32'(len), 32'(len));
    if (rd) chk(rsp_rdata === rexp, "R9", "read data", rsp_rdata, rexp);
    chk(rsp_timeout === tmo_exp && rsp_err === 1'b0, "R7", "timeout/err",
        {30'd0, rsp_err, rsp_timeout}, {31'd0, tmo_exp});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && rsp_done === 1'b0, "R8", "reset pins",
        {29'd0, spi_cs_n, spi_sclk, rsp_done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 1);

    for (int l = 0; l < 8; l++) if (l == 0 || l > 4) begin
      run_bad(1'b1, l);
      run_bad(1'b0, l);
    end

    for (int l = 1; l <= 4; l++) begin
      run_ok(1'b0, l, 16'h0F00 + 16'(l * 16'h0111), 32'h8C4D_2E17 ^ 32'(l), 32'h0, 0);
      run_ok(1'b0, l, 16'hFFFF, 32'hA1B2_C3D4, 32'h0, 0);
    end

    for (int l = 1; l <= 4; l++) begin
      for (int k = 0; k < 6; k++) begin
        int wt;
        case (k)
          0: wt = 0;
          1: wt = 1;
          2: wt = 2;
          3: wt = 5;
          4: wt = MAXP;
          default: wt = MAXP + 1;
        endcase
        run_ok(1'b1, l, 16'h0018 + 16'(k * 4), 32'h0,
               32'hC3A5_5A3C ^ (32'(wt) * 32'h0101_0101) ^ 32'(l), wt);
      end
    end

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule